// File: doc/BRIEF.md
# Bus Clock Band Classifier

This block works out which of four bus-frequency bands a storage controller is clocked in, so that the matching set of interface timings can be chosen. On a start pulse it first looks at a preloaded 32-bit frequency word. If the upper field of that word carries a fixed validity signature, the low 9 bits are used at once as the frequency count. If the signature is absent, the block reads an external 9-bit frequency counter 128 times at evenly spaced moments, sums the readings and takes the truncated mean.

The count is then multiplied by a per-chip base constant, typically 48, 55 or 66. The block treats the truncated quotient of that product by 192 as the bus frequency in MHz and maps it to a 2-bit slot code. The slot codes stand for the 33, 40, 50 and 66 MHz bands. The averaged count, the slot and a one-cycle done pulse are presented to the caller. The count and slot then stay unchanged until the next measurement completes.

Top module: `clk_band_meter`

## Requirements
- R1: After a synchronous active-low reset, `done`, `sample_strobe`, `slot` and `avg_count` are all zero.
- R2: A start with `freq_word[31:12]` equal to 20'hABCDE takes no samples and reports `avg_count` equal to `freq_word[8:0]`. Bits 11:9 of the word have no effect.
- R3: A start with any other value in `freq_word[31:12]` raises `sample_strobe` for exactly 128 single cycles. The value on `sample_value` is captured at the clock edge that ends each strobe cycle.
- R4: The first strobe occurs in the cycle right after the start edge. Successive strobes are exactly `SAMPLE_GAP` cycles apart.
- R5: In the sampling case, `avg_count` equals the sum of the 128 captured values divided by 128, truncated, kept to 9 bits.
- R6: With f = floor(base_const × count / 192), `slot` is 0 when f < 40, 1 when f < 45, 2 when f < 55, and 3 otherwise.
- R7: `done` is high for exactly one cycle per measurement. `slot` and `avg_count` change only in the cycle where `done` is high and hold otherwise.
- R8: A start pulse that arrives while a measurement is in progress is ignored. The running measurement finishes with its own samples.
- R9: In the signature case, `done` is high in the second cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a measurement |
| freq_word | input | 32 | Preloaded frequency word, signature in bits 31:12 |
| base_const | input | 7 | Per-chip base constant, held stable during a measurement |
| sample_strobe | output | 1 | High in each cycle where `sample_value` is captured |
| sample_value | input | 9 | Current reading of the frequency counter |
| slot | output | 2 | Band code 0..3 |
| avg_count | output | 9 | Count used for classification |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch several properties on every cycle. They check that `done` never lasts more than one cycle and that `slot` and `avg_count` never move outside a done cycle. They also check that strobes are isolated single cycles with exactly `SAMPLE_GAP` between them, and that every measurement ends after either zero or 128 strobes. Some properties can only be shown by the bench's scenarios, because they depend on actual values. These are the arithmetic of the mean and of the band split at its edges, the handling of near-miss signatures, the ignored middle bits of the word, and a start pulse that lands in the middle of sampling. The bench sweeps every 9-bit count against all three base constants.

// File: rtl/clk_band_pkg.sv
// Shared types and band constants for the bus clock band classifier.
// Assumes the band edges are given in MHz, with the frequency taken
// as floor(base * count / BAND_DIVISOR).
package clk_band_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_AVERAGE,
        ST_CLASSIFY
    } meter_state_e;

    localparam int BAND_DIVISOR = 192;
    localparam int BAND_COUNT   = 3;
    localparam int BAND_EDGE_MHZ [BAND_COUNT] = '{40, 45, 55};

endpackage

// File: rtl/clk_band_pacer.sv
// Sample pacer: while run is high, raises tick in the first cycle and
// then once every GAP cycles. It restarts from zero whenever run drops.
// Assumes GAP >= 2.
module clk_band_pacer #(
    parameter int GAP = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;

    logic [CW-1:0] cnt;

    // Interval counter, parked at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == CW'(GAP - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // A tick fires at the start of each interval.
    assign tick = run && (cnt == '0);

endmodule

// File: rtl/clk_band_accum.sv
// Sample accumulator: clears on clear, then adds value on each take.
// Flags last on the take that completes SAMPLES readings.
// Assumes SAMPLES is a power of two, at least 2.
module clk_band_accum #(
    parameter int CNT_W   = 9,
    parameter int SAMPLES = 128,
    localparam int LOG_N  = $clog2(SAMPLES),
    localparam int SUM_W  = CNT_W + LOG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [CNT_W-1:0] value,
    output logic [SUM_W-1:0] sum,
    output logic             last
);
    logic [LOG_N-1:0] idx;

    // Running sum and index of the reading being taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            idx <= '0;
        end else if (clear) begin
            sum <= '0;
            idx <= '0;
        end else if (take) begin
            sum <= sum + SUM_W'(value);
            idx <= idx + 1'b1;
        end
    end

    // The final reading of a run.
    assign last = take && (idx == LOG_N'(SAMPLES - 1));

endmodule

// File: rtl/clk_band_classify.sv
// Band comparator: compares base*count against each band edge scaled by
// the divisor. floor(p/D) < E holds exactly when p < E*D, so the result
// matches a truncating divide. Purely combinational.
module clk_band_classify
    import clk_band_pkg::*;
#(
    parameter int BASE_W = 7,
    parameter int CNT_W  = 9
) (
    input  logic [BASE_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    output logic [1:0]        slot
);
    logic [31:0]           product;
    logic [BAND_COUNT-1:0] below;

    assign product = 32'(base) * 32'(count);

    // One comparator per band edge.
    for (genvar i = 0; i < BAND_COUNT; i++) begin : g_edge
        assign below[i] = product < 32'(BAND_EDGE_MHZ[i] * BAND_DIVISOR);
    end

    // The lowest edge that is not reached picks the slot.
    always_comb begin
        if (below[0])      slot = 2'd0;
        else if (below[1]) slot = 2'd1;
        else if (below[2]) slot = 2'd2;
        else               slot = 2'd3;
    end

endmodule

// File: rtl/clk_band_meter.sv
// Bus clock band classifier, top level. On start it checks the preloaded
// word for the signature. It either takes the count from that word or
// averages SAMPLES paced counter readings, then classifies the count
// into a slot. Assumes base_const stays stable through a measurement
// and that start is ignored while busy.
module clk_band_meter
    import clk_band_pkg::*;
#(
    parameter int             WORD_W     = 32,
    parameter int             SIG_W      = 20,
    parameter logic [SIG_W-1:0] SIGNATURE = 20'hABCDE,
    parameter int             CNT_W      = 9,
    parameter int             BASE_W     = 7,
    parameter int             SAMPLES    = 128,
    parameter int             SAMPLE_GAP = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] freq_word,
    input  logic [BASE_W-1:0] base_const,
    output logic              sample_strobe,
    input  logic [CNT_W-1:0]  sample_value,
    output logic [1:0]        slot,
    output logic [CNT_W-1:0]  avg_count,
    output logic              done
);
    localparam int LOG_N   = $clog2(SAMPLES);
    localparam int SUM_W   = CNT_W + LOG_N;
    localparam int SIG_LSB = WORD_W - SIG_W;

    meter_state_e     state;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       slot_q;
    logic [CNT_W-1:0] avg_q;
    logic             done_q;
    logic             sig_ok;
    logic             acc_clear;
    logic             tick;
    logic             acc_last;
    logic [SUM_W-1:0] acc_sum;
    logic [1:0]       band;

    assign sig_ok    = freq_word[WORD_W-1:SIG_LSB] == SIGNATURE;
    assign acc_clear = (state == ST_IDLE) && start && !sig_ok;

    // The bits between the count and the signature carry no meaning.
    if (SIG_LSB > CNT_W) begin : g_gap_bits
        logic unused_gap_bits;
        assign unused_gap_bits = ^freq_word[SIG_LSB-1:CNT_W];
    end

    clk_band_pacer #(.GAP(SAMPLE_GAP)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SAMPLE),
        .tick  (tick)
    );

    clk_band_accum #(.CNT_W(CNT_W), .SAMPLES(SAMPLES)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .take  (tick),
        .value (sample_value),
        .sum   (acc_sum),
        .last  (acc_last)
    );

    clk_band_classify #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_classify (
        .base  (base_const),
        .count (cnt_q),
        .slot  (band)
    );

    // Control sequencer: signature check, sampling, averaging, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt_q  <= '0;
            slot_q <= 2'd0;
            avg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (sig_ok) begin
                            cnt_q <= freq_word[CNT_W-1:0];
                            state <= ST_CLASSIFY;
                        end else begin
                            state <= ST_SAMPLE;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (acc_last) state <= ST_AVERAGE;
                end
                ST_AVERAGE: begin
                    cnt_q <= CNT_W'(acc_sum >> LOG_N);
                    state <= ST_CLASSIFY;
                end
                ST_CLASSIFY: begin
                    slot_q <= band;
                    avg_q  <= cnt_q;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sample_strobe = tick;
    assign slot          = slot_q;
    assign avg_count     = avg_q;
    assign done          = done_q;

endmodule

// File: rtl/clk_band_meter_chk.sv
// Checker for clk_band_meter: watches done, the result outputs and the
// strobe pacing from the ports. Counters stand in for long windows.
module clk_band_meter_chk #(
    parameter int CNT_W      = 9,
    parameter int SAMPLES    = 128,
    parameter int SAMPLE_GAP = 3000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             sample_strobe,
    input logic [1:0]       slot,
    input logic [CNT_W-1:0] avg_count
);
    localparam int SC_W = $clog2(SAMPLES + 1) + 1;
    localparam int GC_W = $clog2(SAMPLE_GAP + 1) + 1;

    logic [SC_W-1:0] strobe_cnt;
    logic [GC_W-1:0] gap_cnt;
    logic            in_run;

    // Strobes seen in the current measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)             strobe_cnt <= '0;
        else if (done)          strobe_cnt <= '0;
        else if (sample_strobe) strobe_cnt <= strobe_cnt + 1'b1;
    end

    // Cycles since the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_cnt <= '0;
        else if (sample_strobe)             gap_cnt <= '0;
        else if (gap_cnt != {GC_W{1'b1}})   gap_cnt <= gap_cnt + 1'b1;
    end

    // Marks that a strobe has already occurred in this measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)             in_run <= 1'b0;
        else if (done)          in_run <= 1'b0;
        else if (sample_strobe) in_run <= 1'b1;
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(slot));

    a_r7_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(avg_count));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    a_r3_strobe_total: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (strobe_cnt == '0 || strobe_cnt == SC_W'(SAMPLES)));

    a_r3_strobe_limit: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> strobe_cnt < SC_W'(SAMPLES));

    a_r4_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && in_run) |-> gap_cnt == GC_W'(SAMPLE_GAP - 1));

    a_r6_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && avg_count == '0) |-> slot == 2'd0);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> (!done && !sample_strobe));

endmodule

bind clk_band_meter clk_band_meter_chk #(
    .CNT_W      (CNT_W),
    .SAMPLES    (SAMPLES),
    .SAMPLE_GAP (SAMPLE_GAP)
) u_meter_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .sample_strobe (sample_strobe),
    .slot          (slot),
    .avg_count     (avg_count)
);

// File: tb/test_clk_band_meter.sv
`timescale 1ns/1ps
module test_clk_band_meter;
    localparam int GAP = 3;
    localparam int N   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] freq_word = '0;
    logic [6:0]  base_const = 7'd48;
    logic        sample_strobe;
    logic [8:0]  sample_value = '0;
    logic [1:0]  slot;
    logic [8:0]  avg_count;
    logic        done;

    int tests = 0;
    int fails = 0;
    int cycle = 0;
    int gen_mode = 0;
    int smp_k = 0;
    int exp_sum = 0;
    int n_strobe = 0;
    int gap_bad = 0;
    int last_cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clk_band_meter #(.SAMPLE_GAP(GAP)) i_clk_band_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .freq_word     (freq_word),
        .base_const    (base_const),
        .sample_strobe (sample_strobe),
        .sample_value  (sample_value),
        .slot          (slot),
        .avg_count     (avg_count),
        .done          (done)
    );

    function automatic int gen(int mode, int k);
        if (mode == 0)      return 0;
        else if (mode == 1) return 511;
        else if (mode == 2) return int'($urandom_range(511, 0));
        else if (mode == 3) return (k * 7 + 3) % 512;
        else                return (mode - 100) % 512;
    endfunction

    function automatic int exp_slot(int base, int cnt);
        int f;
        f = (base * cnt) / 192;
        if (f < 40)      return 0;
        else if (f < 45) return 1;
        else if (f < 55) return 2;
        else             return 3;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Counter model and strobe bookkeeping, away from the active edge.
    always @(negedge clk) begin
        int v;
        cycle++;
        v = gen(gen_mode, smp_k);
        sample_value = 9'(v);
        if (sample_strobe) begin
            if (n_strobe > 0 && (cycle - last_cyc) != GAP) gap_bad++;
            last_cyc = cycle;
            n_strobe++;
            exp_sum += v;
            smp_k++;
        end
        if (cycle > 150000 && !finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Signature path: R2, R6, R7, R9.
    task automatic run_sig(logic [31:0] word, int base);
        @(negedge clk);
        freq_word = word; base_const = 7'(base); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9 early", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R9 done", int'(done), 1);
        chk(avg_count == word[8:0], "R2 count", int'(avg_count), int'(word[8:0]));
        chk(slot == 2'(exp_slot(base, int'(word[8:0]))), "R6 slot",
            int'(slot), exp_slot(base, int'(word[8:0])));
        @(negedge clk);
        chk(done == 1'b0, "R7 pulse", int'(done), 0);
    endtask

    // Sampling path: R3, R4, R5, R6, and R8 when poke is set.
    task automatic run_fb(logic [31:0] word, int base, int mode, bit poke);
        int waitn;
        int expv;
        @(negedge clk);
        exp_sum = 0; n_strobe = 0; gap_bad = 0; smp_k = 0; gen_mode = mode;
        freq_word = word; base_const = 7'(base); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sample_strobe == 1'b1, "R4 first strobe", int'(sample_strobe), 1);
        waitn = 0;
        while (done !== 1'b1 && waitn < 5000) begin
            @(negedge clk);
            waitn++;
            if (poke && waitn == 40) begin
                freq_word = {20'hABCDE, 12'h0FF};
                start = 1'b1;
            end
            if (poke && waitn == 41) start = 1'b0;
        end
        chk(waitn < 5000, "R3 completes", waitn, 0);
        chk(n_strobe == N, poke ? "R8 strobes" : "R3 strobes", n_strobe, N);
        chk(gap_bad == 0, "R4 spacing", gap_bad, 0);
        expv = (exp_sum / N) % 512;
        chk(int'(avg_count) == expv, poke ? "R8 average" : "R5 average",
            int'(avg_count), expv);
        chk(int'(slot) == exp_slot(base, expv), "R6 slot", int'(slot),
            exp_slot(base, expv));
        @(negedge clk);
        chk(done == 1'b0, "R7 pulse", int'(done), 0);
    endtask

    initial begin
        int bases [3] = '{48, 55, 66};
        logic [1:0] hold_slot;
        logic [8:0] hold_avg;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(sample_strobe == 1'b0, "R1 strobe", int'(sample_strobe), 0);
        chk(slot == 2'd0, "R1 slot", int'(slot), 0);
        chk(avg_count == 9'd0, "R1 avg", int'(avg_count), 0);

        // Full sweep of counts and bases through the signature path.
        for (int b = 0; b < 3; b++) begin
            for (int c = 0; c < 512; c++) begin
                run_sig({20'hABCDE, 3'(c % 8), 9'(c)}, bases[b]);
            end
        end

        // Sampling path under several counter patterns and near-miss words.
        run_fb(32'h0000_0000, 48, 0, 1'b0);
        run_fb({20'hABCDF, 12'h1FF}, 66, 1, 1'b0);
        run_fb({20'h2BCDE, 12'h010}, 55, 3, 1'b0);
        run_fb({20'hABCDE ^ 20'h80000, 12'h020}, 48, 2, 1'b0);
        run_fb(32'h1234_5678, 48, 100 + 159, 1'b0);
        run_fb(32'h1234_5678, 48, 100 + 160, 1'b0);
        run_fb(32'hFFFF_FFFF, 66, 2, 1'b0);
        // R8: start pulse in the middle of sampling
        run_fb(32'h0000_0100, 55, 2, 1'b1);

        // R7: results hold after done while inputs move.
        hold_slot = slot; hold_avg = avg_count;
        freq_word = 32'h0000_0001; base_const = 7'd66;
        repeat (8) @(negedge clk);
        chk(slot == hold_slot, "R7 slot hold", int'(slot), int'(hold_slot));
        chk(avg_count == hold_avg, "R7 avg hold", int'(avg_count), int'(hold_avg));
        chk(done == 1'b0, "R7 no done", int'(done), 0);
        chk(sample_strobe == 1'b0, "R3 idle strobe", int'(sample_strobe), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule